// File: doc/BRIEF.md
# Microcoded Frame-Processing Sequencer

This block is a small microprogrammed engine that walks a writable store of 256 instruction words and processes a stream of frame data words. Each instruction word is 48 bits wide. Its low nibble is the opcode, bits 16:4 hold the per-instruction control flags, bits 31:24 hold a branch target and bits 47:32 hold a 16-bit immediate. The engine feeds one of eight operand sources through an optional one-bit left shift and an optional single-nibble AND mask. It can write the result into any combination of four working registers. A loop counter loads straight from the immediate.

Flow control consists of four opcodes: an unconditional jump, a call that saves a single return pointer, a return, and a branch steered by a static strap pin. The strap lets one microprogram serve both the receive and the transmit paths. Each instruction chooses whether it issues on the next clock or waits for a data-valid strobe. Each instruction also drives a ready output that paces the data source. The store is loaded through a synchronous write port and read synchronously, so the current instruction is a registered word.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pc` is 0, every working register and the loop counter read 0, and `req_next` is low.
- R2: An instruction with opcode 0xC jumps to its bits 31:24. Any opcode from 0x0 to 0xB advances `pc` by one.
- R3: Opcode 0xD jumps to bits 31:24 and saves `pc`+1 in a single return slot. Opcode 0xE continues at the saved value. A second call before a return overwrites the slot.
- R4: Opcode 0xF continues at bits 31:24 when `strap_rx` is high, and at immediate bits 7:0 (word bits 39:32) when it is low.
- R5: When bit 4 is 1 the instruction executes at the next clock edge. When bit 4 is 0 it executes at the first edge with `data_valid` high. While it waits, `pc`, the working registers and the loop counter hold their values.
- R6: `req_next` equals bit 5 of the instruction currently held, and it moves to the next instruction's bit once that instruction is fetched.
- R7: Bits 6, 7, 8 and 9 load the result into WR1, WR2, WR3 and WR4, one bit per register. Any set of them may be set together. `wr_flat` presents WR1 in bits 15:0 up to WR4 in bits 63:48.
- R8: Bit 10 loads the loop counter from the immediate (word bits 47:32).
- R9: Bits 16:14 choose the operand: 0 immediate, 1 `frame_in`, 2 WR1, 3 WR2, 4 WR3, 5 WR4, 6 loop counter, 7 `rd_data`.
- R10: Bit 11 shifts the operand left by one position and fills with zero. When bit 11 is clear the operand passes unchanged.
- R11: Bit 12 ANDs one nibble of the shifted operand and leaves the other nibbles unchanged. With bit 13 clear, immediate bits 2:1 choose the nibble (0 = bits 3:0) and immediate bits 7:4 give the mask. With bit 13 set, immediate bits 13:12 choose the nibble and immediate bits 3:0 give the mask.
- R12: A write through `prog_we`/`prog_addr`/`prog_data` replaces the stored word. While `pc` holds the written address, the new word takes effect at the second clock edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Store write enable |
| prog_addr | input | 8 | Store write address |
| prog_data | input | 48 | Instruction word to write |
| strap_rx | input | 1 | Static direction strap for opcode 0xF |
| data_valid | input | 1 | Incoming frame word is valid |
| frame_in | input | 16 | Incoming frame data word |
| rd_data | input | 16 | External read data operand |
| req_next | output | 1 | Ready for the next frame word |
| pc | output | 8 | Program counter |
| wr_flat | output | 64 | Working registers WR4..WR1 packed |
| loop_cnt | output | 16 | Loop counter |

## Verification
The bench builds the block with its default parameters: an 8-bit program counter over the full 256-word store and 16-bit data. These defaults let branch targets land well apart in the address space (0x20 to 0x90). The 16-bit data width gives four nibbles, so the mask test can reach the top nibble and the shift can carry bits across nibble boundaries. The bench runs one program with the strap high and again with it low after a mid-run reset. It also holds a waiting instruction for several cycles and rewrites a looping word at run time.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam logic [3:0] OP_JUMP  = 4'hC;
  localparam logic [3:0] OP_CALL  = 4'hD;
  localparam logic [3:0] OP_RET   = 4'hE;
  localparam logic [3:0] OP_STRAP = 4'hF;

  localparam int B_ONCLK = 4;
  localparam int B_REQ   = 5;
  localparam int B_LDWR  = 6;
  localparam int B_LDLC  = 10;
  localparam int B_SHIFT = 11;
  localparam int B_MEN   = 12;
  localparam int B_MSEL  = 13;
  localparam int B_SRC   = 14;
  localparam int B_BR    = 24;
  localparam int B_IMM   = 32;
  localparam int NUM_WR  = 4;

  localparam logic [2:0] SRC_IMM   = 3'd0;
  localparam logic [2:0] SRC_FRAME = 3'd1;
  localparam logic [2:0] SRC_WR1   = 3'd2;
  localparam logic [2:0] SRC_WR2   = 3'd3;
  localparam logic [2:0] SRC_WR3   = 3'd4;
  localparam logic [2:0] SRC_WR4   = 3'd5;
  localparam logic [2:0] SRC_LC    = 3'd6;
  localparam logic [2:0] SRC_RD    = 3'd7;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int AW = 8,
  parameter int IW = 48
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/useq_control.sv
module useq_control
  import useq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [3:0]    op,
  input  logic [AW-1:0] br_addr,
  input  logic [AW-1:0] imm_low,
  input  logic          strap,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] nxt_pc
);
  logic [AW-1:0] ret_q;
  logic [AW-1:0] pc_inc;
  logic [AW-1:0] target;

  always_comb begin
    pc_inc = pc_q + {{(AW-1){1'b0}}, 1'b1};
    target = pc_inc;
    case (op)
      OP_JUMP, OP_CALL: target = br_addr;
      OP_RET:           target = ret_q;
      OP_STRAP:         target = strap ? br_addr : imm_low;
      default:          target = pc_inc;
    endcase
    nxt_pc = fire ? target : pc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ret_q <= '0;
    end else begin
      pc_q <= nxt_pc;
      if (fire && op == OP_CALL) ret_q <= pc_inc;
    end
  end

  assert_stall_pc_R5: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(pc_q));
  assert_return_R3: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_RET) |=> pc_q == $past(ret_q));
  assert_strap_high_R4: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_STRAP && strap) |=> pc_q == $past(br_addr));
  assert_strap_low_R4: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_STRAP && !strap) |=> pc_q == $past(imm_low));
endmodule

// File: rtl/useq_datapath.sv
module useq_datapath
  import useq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic [NUM_WR-1:0]    ld_wr,
  input  logic                 ld_lc,
  input  logic                 shift_en,
  input  logic                 mask_en,
  input  logic                 mask_sel,
  input  logic [2:0]           src,
  input  logic [DW-1:0]        imm,
  input  logic [DW-1:0]        frame_in,
  input  logic [DW-1:0]        rd_data,
  output logic [NUM_WR*DW-1:0] wr_flat,
  output logic [DW-1:0]        lc_q
);
  localparam int NIBS = DW / 4;
  localparam int NIW  = (NIBS > 1) ? $clog2(NIBS) : 1;

  logic [DW-1:0]  wr_q [NUM_WR];
  logic [DW-1:0]  operand;
  logic [DW-1:0]  shifted;
  logic [DW-1:0]  result;
  logic [NIW-1:0] nib_idx;
  logic [3:0]     nib_mask;

  always_comb begin
    case (src)
      SRC_IMM:   operand = imm;
      SRC_FRAME: operand = frame_in;
      SRC_WR1:   operand = wr_q[0];
      SRC_WR2:   operand = wr_q[1];
      SRC_WR3:   operand = wr_q[2];
      SRC_WR4:   operand = wr_q[3];
      SRC_LC:    operand = lc_q;
      default:   operand = rd_data;
    endcase
    shifted  = shift_en ? {operand[DW-2:0], 1'b0} : operand;
    nib_idx  = mask_sel ? imm[12 +: NIW] : imm[1 +: NIW];
    nib_mask = mask_sel ? imm[3:0] : imm[7:4];
    result   = shifted;
    if (mask_en) result[nib_idx*4 +: 4] = shifted[nib_idx*4 +: 4] & nib_mask;
  end

  for (genvar i = 0; i < NUM_WR; i++) begin : g_wr
    always_ff @(posedge clk) begin
      if (rst)                  wr_q[i] <= '0;
      else if (fire && ld_wr[i]) wr_q[i] <= result;
    end
    assign wr_flat[i*DW +: DW] = wr_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)                lc_q <= '0;
    else if (fire && ld_lc) lc_q <= imm;
  end

  assert_stall_regs_R5: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ($stable(wr_flat) && $stable(lc_q)));
  assert_lc_load_R8: assert property (@(posedge clk) disable iff (rst)
    (fire && ld_lc) |=> lc_q == $past(imm));
  assert_wr1_load_R7: assert property (@(posedge clk) disable iff (rst)
    (fire && ld_wr[0]) |=> wr_flat[DW-1:0] == $past(result));
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import useq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       prog_we,
  input  logic [ADDR_W-1:0]          prog_addr,
  input  logic [DATA_W+31:0]         prog_data,
  input  logic                       strap_rx,
  input  logic                       data_valid,
  input  logic [DATA_W-1:0]          frame_in,
  input  logic [DATA_W-1:0]          rd_data,
  output logic                       req_next,
  output logic [ADDR_W-1:0]          pc,
  output logic [NUM_WR*DATA_W-1:0]   wr_flat,
  output logic [DATA_W-1:0]          loop_cnt
);
  localparam int IW = DATA_W + 32;

  typedef struct packed {
    logic [3:0]        op;
    logic              on_clk;
    logic              req;
    logic [NUM_WR-1:0] ld_wr;
    logic              ld_lc;
    logic              shift_en;
    logic              mask_en;
    logic              mask_sel;
    logic [2:0]        src;
    logic [ADDR_W-1:0] br;
    logic [DATA_W-1:0] imm;
  } ctl_t;

  function automatic ctl_t decode(input logic [IW-1:0] w);
    ctl_t c;
    c.op       = w[3:0];
    c.on_clk   = w[B_ONCLK];
    c.req      = w[B_REQ];
    c.ld_wr    = w[B_LDWR +: NUM_WR];
    c.ld_lc    = w[B_LDLC];
    c.shift_en = w[B_SHIFT];
    c.mask_en  = w[B_MEN];
    c.mask_sel = w[B_MSEL];
    c.src      = w[B_SRC +: 3];
    c.br       = w[B_BR +: ADDR_W];
    c.imm      = w[B_IMM +: DATA_W];
    return c;
  endfunction

  logic [IW-1:0]     ir;
  ctl_t              ctl;
  logic              active_q;
  logic              fire;
  logic [ADDR_W-1:0] nxt_pc;
  logic [ADDR_W-1:0] rd_addr;

  always_ff @(posedge clk) active_q <= ~rst;

  assign ctl      = decode(ir);
  assign fire     = active_q & (ctl.on_clk | data_valid);
  assign req_next = active_q & ctl.req;
  assign rd_addr  = rst ? '0 : nxt_pc;

  useq_store #(.AW(ADDR_W), .IW(IW)) u_store (
    .clk   (clk),
    .we    (prog_we),
    .waddr (prog_addr),
    .wdata (prog_data),
    .raddr (rd_addr),
    .rdata (ir)
  );

  useq_control #(.AW(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .fire    (fire),
    .op      (ctl.op),
    .br_addr (ctl.br),
    .imm_low (ctl.imm[ADDR_W-1:0]),
    .strap   (strap_rx),
    .pc_q    (pc),
    .nxt_pc  (nxt_pc)
  );

  useq_datapath #(.DW(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .ld_wr    (ctl.ld_wr),
    .ld_lc    (ctl.ld_lc),
    .shift_en (ctl.shift_en),
    .mask_en  (ctl.mask_en),
    .mask_sel (ctl.mask_sel),
    .src      (ctl.src),
    .imm      (ctl.imm),
    .frame_in (frame_in),
    .rd_data  (rd_data),
    .wr_flat  (wr_flat),
    .lc_q     (loop_cnt)
  );

  assert_wait_dv_R5: assert property (@(posedge clk) disable iff (rst)
    (active_q && !ctl.on_clk && !data_valid) |=> $stable(pc));
  assert_req_reset_R1: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> !req_next);
endmodule

// File: tb/sim_ucode_sequencer.sv
module sim_ucode_sequencer;
  logic        clk = 1'b0;
  logic        rst;
  logic        prog_we;
  logic [7:0]  prog_addr;
  logic [47:0] prog_data;
  logic        strap_rx;
  logic        data_valid;
  logic [15:0] frame_in;
  logic [15:0] rd_data;
  logic        req_next;
  logic [7:0]  pc;
  logic [63:0] wr_flat;
  logic [15:0] loop_cnt;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ucode_sequencer u0 (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .strap_rx(strap_rx), .data_valid(data_valid),
    .frame_in(frame_in), .rd_data(rd_data), .req_next(req_next), .pc(pc),
    .wr_flat(wr_flat), .loop_cnt(loop_cnt)
  );

  // Steps of the main program: {expected pc, register (0-3 WR1..WR4, 4 LC), value}
  localparam int NSTEP = 14;
  localparam logic [26:0] STEPS [NSTEP] = '{
    {8'h01, 3'd0, 16'h1234},  // R9 immediate, R7
    {8'h02, 3'd1, 16'h2468},  // R10 shift
    {8'h03, 3'd2, 16'h2428},  // R11 mask mode 0
    {8'h04, 3'd3, 16'h0428},  // R11 mask mode 1
    {8'h05, 3'd4, 16'h00A5},  // R8 loop counter
    {8'h06, 3'd3, 16'h00A5},  // R7 two registers at once
    {8'h07, 3'd2, 16'h5A5A},  // R9 read data
    {8'h20, 3'd0, 16'hBEEF},  // R3 call, R9 frame data
    {8'h30, 3'd3, 16'h00A5},  // R4 strap high
    {8'h08, 3'd3, 16'h7777},  // R3 return
    {8'h50, 3'd2, 16'h5A5A},  // R2 jump
    {8'h60, 3'd1, 16'h00A5},  // R3 call
    {8'h70, 3'd0, 16'hBEEF},  // R3 second call
    {8'h61, 3'd3, 16'h7777}   // R3 return to overwritten slot
  };

  function automatic logic [47:0] ins(input logic [3:0] op, input logic onclk,
      input logic req, input logic [3:0] ld, input logic lc, input logic sh,
      input logic men, input logic msel, input logic [2:0] src,
      input logic [7:0] br, input logic [15:0] d);
    return {d, br, 7'd0, src, msel, men, sh, lc, ld, req, onclk, op};
  endfunction

  function automatic logic [15:0] regval(input logic [2:0] which);
    if (which == 3'd4) return loop_cnt;
    return wr_flat[which*16 +: 16];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] a, input logic [47:0] w);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = a; prog_data = w;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; prog_we = 1'b0; prog_addr = '0; prog_data = '0;
    strap_rx = 1'b1; data_valid = 1'b0; frame_in = 16'hBEEF; rd_data = 16'h5A5A;

    load(8'h00, ins(4'h0, 1, 0, 4'b0001, 0, 0, 0, 0, 3'd0, 8'h00, 16'h1234));
    load(8'h01, ins(4'h0, 1, 0, 4'b0010, 0, 1, 0, 0, 3'd2, 8'h00, 16'h0000));
    load(8'h02, ins(4'h0, 1, 0, 4'b0100, 0, 0, 1, 0, 3'd3, 8'h00, 16'h0032));
    load(8'h03, ins(4'h0, 1, 0, 4'b1000, 0, 0, 1, 1, 3'd4, 8'h00, 16'h3005));
    load(8'h04, ins(4'h0, 1, 0, 4'b0001, 1, 0, 0, 0, 3'd1, 8'h00, 16'h00A5));
    load(8'h05, ins(4'h0, 1, 0, 4'b1010, 0, 0, 0, 0, 3'd6, 8'h00, 16'h0000));
    load(8'h06, ins(4'h0, 1, 0, 4'b0100, 0, 0, 0, 0, 3'd7, 8'h00, 16'h0000));
    load(8'h07, ins(4'hD, 1, 0, 4'b0000, 0, 0, 0, 0, 3'd0, 8'h20, 16'h0000));
    load(8'h20, ins(4'hF, 1, 0, 4'b0000, 0, 0, 0, 0, 3'd0, 8'h30, 16'h0040));
    load(8'h30, ins(4'hE, 1, 0, 4'b1000, 0, 0, 0, 0, 3'd0, 8'h00, 16'h7777));
    load(8'h08, ins(4'hC, 1, 0, 4'b0000, 0, 0, 0, 0, 3'd0, 8'h50, 16'h0000));
    load(8'h50, ins(4'hD, 1, 0, 4'b0000, 0, 0, 0, 0, 3'd0, 8'h60, 16'h0000));
    load(8'h60, ins(4'hD, 1, 0, 4'b0000, 0, 0, 0, 0, 3'd0, 8'h70, 16'h0000));
    load(8'h70, ins(4'hE, 1, 0, 4'b0000, 0, 0, 0, 0, 3'd0, 8'h00, 16'h0000));
    load(8'h61, ins(4'h0, 0, 1, 4'b0001, 0, 0, 0, 0, 3'd0, 8'h00, 16'h9999));
    load(8'h62, ins(4'hF, 1, 0, 4'b0000, 0, 0, 0, 0, 3'd0, 8'h80, 16'h0090));
    load(8'h80, ins(4'hC, 1, 0, 4'b0000, 0, 0, 0, 0, 3'd0, 8'h80, 16'h0000));
    load(8'h40, ins(4'hC, 1, 0, 4'b0000, 0, 0, 0, 0, 3'd0, 8'h40, 16'h0000));
    load(8'h90, ins(4'hC, 1, 0, 4'b0000, 0, 0, 0, 0, 3'd0, 8'h90, 16'h0000));

    // R1 reset state
    chk("R1 pc in reset", pc, 8'h00);
    chk("R1 regs in reset", wr_flat, 64'h0);
    chk("R1 lc in reset", loop_cnt, 16'h0);
    chk("R1 req in reset", req_next, 1'b0);

    rst = 1'b0;
    step();  // fetch of word 0
    chk("R1 pc after release", pc, 8'h00);
    chk("R1 req after release", req_next, 1'b0);

    for (int i = 0; i < NSTEP; i++) begin
      step();
      chk($sformatf("R2/R3 pc step %0d", i), pc, STEPS[i][26:19]);
      chk($sformatf("R7 reg value step %0d", i), regval(STEPS[i][18:16]), STEPS[i][15:0]);
    end

    // R7 WR2 kept value from the multi-load step
    chk("R7 WR2 from multi-load", wr_flat[31:16], 16'h00A5);
    // R6 waiting instruction at 0x61 requests data
    chk("R6 req high", req_next, 1'b1);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R5 pc held while waiting", pc, 8'h61);
      chk("R5 WR1 held while waiting", wr_flat[15:0], 16'hBEEF);
    end
    data_valid = 1'b1;
    step();
    data_valid = 1'b0;
    chk("R5 pc after valid", pc, 8'h62);
    chk("R5 WR1 after valid", wr_flat[15:0], 16'h9999);
    chk("R6 req follows next word", req_next, 1'b0);
    step();
    chk("R4 strap high target", pc, 8'h80);

    // Mid-run reset, strap low
    rst = 1'b1; strap_rx = 1'b0;
    step();
    chk("R1 pc after reset", pc, 8'h00);
    chk("R1 regs after reset", wr_flat, 64'h0);
    chk("R1 lc after reset", loop_cnt, 16'h0);
    chk("R1 req after reset", req_next, 1'b0);
    rst = 1'b0;
    step();
    for (int i = 0; i < 8; i++) step();
    chk("R3 call reached 0x20", pc, 8'h20);
    step();
    chk("R4 strap low uses immediate", pc, 8'h40);
    step();
    chk("R2 jump to self", pc, 8'h40);

    // R12 rewrite the word at 0x40 while running
    prog_we = 1'b1; prog_addr = 8'h40;
    prog_data = ins(4'h0, 1, 0, 4'b0001, 0, 0, 0, 0, 3'd0, 8'h00, 16'hCAFE);
    step();
    prog_we = 1'b0;
    step();
    chk("R12 old word still looping", pc, 8'h40);
    step();
    chk("R12 new word executed", wr_flat[15:0], 16'hCAFE);
    chk("R2 advance by one", pc, 8'h41);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule